// File: doc/BRIEF.md
# Split-Field Duty Code Counter

This block keeps the duty-cycle code of a digital pulse-width modulator that regulates a DC-DC converter. Once per switching period the control loop presents a one-bit comparison result together with a single-cycle enable strobe, and the counter moves the duty code one step. A high comparison result means the reference sits below the converter output, which calls for a wider pulse, so the code goes up. A low result moves it down.

The code is not kept as one binary number. The fine part is a 16-bit thermometer vector: a run of ones starting at bit 0, grown or shrunk by one position per step. The coarse part is a 3-bit binary count. A full thermometer that is stepped up carries into the coarse count, and an empty thermometer that is stepped down borrows from it. The block presents the raw thermometer vector, the coarse count, a one-hot selection of one of 16 fine lines, and a combined 7-bit binary duty code for downstream logic. Because a full thermometer is a held state before the carry, the fine position is capped at 15, and the combined code repeats that value once per coarse block.

Top module: `hybrid_duty_counter`

## Requirements
- R1: After reset the thermometer vector is all zeros, the coarse count is 0, the combined duty code is 0 and the line selection is 16'h0001.
- R2: With stepEn high and stepUp high and the thermometer not all ones, the thermometer gains one more set bit at its lowest clear position on the next clock edge, and the coarse count is unchanged.
- R3: With stepEn high and stepUp low and the thermometer not all zeros, the highest set bit of the thermometer is cleared on the next clock edge, and the coarse count is unchanged.
- R4: With stepEn high, stepUp high, the thermometer all ones and the coarse count below 7, the next edge clears the thermometer to all zeros and adds one to the coarse count.
- R5: With stepEn high, stepUp low, the thermometer all zeros and the coarse count above 0, the next edge fills the thermometer with all ones and subtracts one from the coarse count.
- R6: With the coarse count at 7 and the thermometer all ones, a step up leaves both fields unchanged.
- R7: With the coarse count at 0 and the thermometer all zeros, a step down leaves both fields unchanged.
- R8: While stepEn is low, neither field changes, whatever stepUp does.
- R9: The thermometer vector is always a contiguous run of ones starting at bit 0 (possibly empty).
- R10: The duty code equals 16 times the coarse count plus the fine index, where the fine index is the number of ones in the thermometer limited to 15.
- R11: The line selection is one-hot, with its single set bit at the fine index of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | Single-cycle strobe, once per switching period |
| stepUp | input | 1 | Comparison result: 1 steps the code up, 0 steps it down |
| thermCode | output | 16 | Fine thermometer field |
| coarseCode | output | 3 | Coarse binary field |
| lineSel | output | 16 | One-hot fine line selection |
| dutyCode | output | 7 | Combined binary duty code |

## Verification
The hardest situation to reach is the top of the range: the coarse count at 7 with a full thermometer, which needs 135 consecutive up steps from reset, each carry boundary crossed on the way. The bench walks there with a loop of enabled up steps, checking every intermediate state against its own model of the two fields, then pushes extra up steps to confirm saturation, and later descends to the bottom the same way. Borrow is reached right after a carry by a single down step, which exercises the wrap to a full thermometer from a nonzero coarse count.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  // Strobes from the step decision logic to the field registers.
  typedef struct packed {
    logic incTherm;
    logic decTherm;
    logic carry;
    logic borrow;
  } hdcStrobes_t;
endpackage

// File: rtl/hdc_ctrl.sv
module hdc_ctrl
  import hdc_pkg::*;
(
  input  logic        stepEn,
  input  logic        stepUp,
  input  logic        thermFull,
  input  logic        thermEmpty,
  input  logic        coarseMax,
  input  logic        coarseMin,
  output hdcStrobes_t strobes
);
  logic wantUp;
  logic wantDown;

  always_comb begin
    wantUp           = stepEn & stepUp;
    wantDown         = stepEn & ~stepUp;
    strobes.incTherm = wantUp & ~thermFull;
    strobes.carry    = wantUp & thermFull & ~coarseMax;
    strobes.decTherm = wantDown & ~thermEmpty;
    strobes.borrow   = wantDown & thermEmpty & ~coarseMin;
  end
endmodule

// File: rtl/hdc_datapath.sv
module hdc_datapath
  import hdc_pkg::*;
#(
  parameter int THERM_W = 16,
  parameter int BIN_W   = 3,
  localparam int LOW_W  = $clog2(THERM_W),
  localparam int CNT_W  = LOW_W + 1,
  localparam int DUTY_W = LOW_W + BIN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  hdcStrobes_t        strobes,
  output logic               thermFull,
  output logic               thermEmpty,
  output logic               coarseMax,
  output logic               coarseMin,
  output logic [THERM_W-1:0] thermCode,
  output logic [BIN_W-1:0]   coarseCode,
  output logic [THERM_W-1:0] lineSel,
  output logic [DUTY_W-1:0]  dutyCode
);
  logic [THERM_W-1:0] thermQ;
  logic [THERM_W-1:0] thermNext;
  logic [BIN_W-1:0]   coarseQ;
  logic [CNT_W-1:0]   onesCount;
  logic [LOW_W-1:0]   fineIdx;

  // Per-bit next state: shift in from below, shift out from above, or wrap.
  for (genvar i = 0; i < THERM_W; i++) begin : g_thermBit
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : g_bottom
      assign fromBelow = 1'b1;
    end else begin : g_mid
      assign fromBelow = thermQ[i-1];
    end
    if (i == THERM_W - 1) begin : g_top
      assign fromAbove = 1'b0;
    end else begin : g_low
      assign fromAbove = thermQ[i+1];
    end
    always_comb begin
      if (strobes.incTherm)      thermNext[i] = fromBelow;
      else if (strobes.decTherm) thermNext[i] = fromAbove;
      else if (strobes.carry)    thermNext[i] = 1'b0;
      else if (strobes.borrow)   thermNext[i] = 1'b1;
      else                       thermNext[i] = thermQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thermQ  <= '0;
      coarseQ <= '0;
    end else begin
      thermQ <= thermNext;
      if (strobes.carry)       coarseQ <= coarseQ + 1'b1;
      else if (strobes.borrow) coarseQ <= coarseQ - 1'b1;
    end
  end

  always_comb begin
    onesCount = '0;
    for (int k = 0; k < THERM_W; k++) onesCount = onesCount + CNT_W'(thermQ[k]);
    if (onesCount > CNT_W'(THERM_W - 1)) fineIdx = LOW_W'(THERM_W - 1);
    else                                 fineIdx = onesCount[LOW_W-1:0];
  end

  assign thermFull  = &thermQ;
  assign thermEmpty = ~|thermQ;
  assign coarseMax  = &coarseQ;
  assign coarseMin  = ~|coarseQ;
  assign thermCode  = thermQ;
  assign coarseCode = coarseQ;
  assign dutyCode   = {coarseQ, fineIdx};
  assign lineSel    = THERM_W'(1) << fineIdx;
endmodule

// File: rtl/hybrid_duty_counter.sv
module hybrid_duty_counter
  import hdc_pkg::*;
#(
  parameter int THERM_W = 16,
  parameter int BIN_W   = 3,
  localparam int LOW_W  = $clog2(THERM_W),
  localparam int DUTY_W = LOW_W + BIN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepEn,
  input  logic               stepUp,
  output logic [THERM_W-1:0] thermCode,
  output logic [BIN_W-1:0]   coarseCode,
  output logic [THERM_W-1:0] lineSel,
  output logic [DUTY_W-1:0]  dutyCode
);
  hdcStrobes_t strobes;
  logic thermFull, thermEmpty, coarseMax, coarseMin;

  hdc_ctrl u_ctrl (
    .stepEn     (stepEn),
    .stepUp     (stepUp),
    .thermFull  (thermFull),
    .thermEmpty (thermEmpty),
    .coarseMax  (coarseMax),
    .coarseMin  (coarseMin),
    .strobes    (strobes)
  );

  hdc_datapath #(.THERM_W(THERM_W), .BIN_W(BIN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .thermFull  (thermFull),
    .thermEmpty (thermEmpty),
    .coarseMax  (coarseMax),
    .coarseMin  (coarseMin),
    .thermCode  (thermCode),
    .coarseCode (coarseCode),
    .lineSel    (lineSel),
    .dutyCode   (dutyCode)
  );
endmodule

// File: rtl/hdc_checker.sv
module hdc_checker #(
  parameter int THERM_W = 16,
  parameter int BIN_W   = 3,
  localparam int LOW_W  = $clog2(THERM_W),
  localparam int DUTY_W = LOW_W + BIN_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               stepEn,
  input logic               stepUp,
  input logic [THERM_W-1:0] thermCode,
  input logic [BIN_W-1:0]   coarseCode,
  input logic [THERM_W-1:0] lineSel,
  input logic [DUTY_W-1:0]  dutyCode
);
  logic [BIN_W-1:0]   coarseTop;
  logic [THERM_W-1:0] thermAll;
  assign coarseTop = '1;
  assign thermAll  = '1;

  // R9
  therm_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (thermCode & (thermCode + THERM_W'(1))) == '0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(thermCode) && $stable(coarseCode));

  // R2
  fine_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && stepUp && thermCode != thermAll |=>
      thermCode == {$past(thermCode[THERM_W-2:0]), 1'b1} && $stable(coarseCode));

  // R3
  fine_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !stepUp && thermCode != '0 |=>
      thermCode == {1'b0, $past(thermCode[THERM_W-1:1])} && $stable(coarseCode));

  // R4
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && stepUp && thermCode == thermAll && coarseCode != coarseTop |=>
      thermCode == '0 && coarseCode == $past(coarseCode) + BIN_W'(1));

  // R5
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !stepUp && thermCode == '0 && coarseCode != '0 |=>
      thermCode == thermAll && coarseCode == $past(coarseCode) - BIN_W'(1));

  // R6
  top_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && stepUp && thermCode == thermAll && coarseCode == coarseTop |=>
      $stable(thermCode) && $stable(coarseCode));

  // R7
  bottom_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepEn && !stepUp && thermCode == '0 && coarseCode == '0 |=>
      $stable(thermCode) && $stable(coarseCode));

  // R11
  line_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lineSel) == 1);

  // R10
  duty_coarse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dutyCode[DUTY_W-1:LOW_W] == coarseCode);
endmodule

bind hybrid_duty_counter hdc_checker #(.THERM_W(THERM_W), .BIN_W(BIN_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stepEn     (stepEn),
  .stepUp     (stepUp),
  .thermCode  (thermCode),
  .coarseCode (coarseCode),
  .lineSel    (lineSel),
  .dutyCode   (dutyCode)
);

// File: tb/hybrid_duty_counter_tb.sv
module hybrid_duty_counter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic        stepUp = 1'b0;
  logic [15:0] thermCode;
  logic [2:0]  coarseCode;
  logic [15:0] lineSel;
  logic [6:0]  dutyCode;

  int applied = 0;
  int misses  = 0;
  bit done    = 1'b0;
  int mOnes   = 0;   // bench model: number of ones in the fine field
  int mCoarse = 0;   // bench model: coarse count

  always #4 clk = ~clk;

  hybrid_duty_counter u_dut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .stepUp(stepUp),
    .thermCode(thermCode), .coarseCode(coarseCode),
    .lineSel(lineSel), .dutyCode(dutyCode)
  );

  // Vector: {stepUp, expected ones (5b), expected coarse (3b)}, from reset.
  localparam logic [8:0] VEC [0:9] = '{
    {1'b1, 5'd1, 3'd0},   // R2
    {1'b0, 5'd0, 3'd0},   // R3
    {1'b0, 5'd0, 3'd0},   // R7
    {1'b1, 5'd1, 3'd0},
    {1'b1, 5'd2, 3'd0},
    {1'b1, 5'd3, 3'd0},
    {1'b0, 5'd2, 3'd0},
    {1'b1, 5'd3, 3'd0},
    {1'b0, 5'd2, 3'd0},
    {1'b0, 5'd1, 3'd0}
  };

  task automatic checkState(input string tag, input int ones, input int coarse);
    logic [15:0] eTherm;
    logic [15:0] eLine;
    int          fine;
    logic [6:0]  eDuty;
    eTherm = '0;
    for (int i = 0; i < 16; i++) if (i < ones) eTherm[i] = 1'b1;
    fine  = (ones > 15) ? 15 : ones;
    eLine = 16'h0001 << fine;
    eDuty = 7'(coarse * 16 + fine);
    applied++;
    if (thermCode !== eTherm || coarseCode !== 3'(coarse)) begin
      misses++;
      $display("FAIL %s fields: therm=%h coarse=%0d expected therm=%h coarse=%0d",
               tag, thermCode, coarseCode, eTherm, coarse);
    end else if (dutyCode !== eDuty) begin
      misses++;
      $display("FAIL %s R10 duty: got %0d expected %0d", tag, dutyCode, eDuty);
    end else if (lineSel !== eLine) begin
      misses++;
      $display("FAIL %s R11 line: got %h expected %h", tag, lineSel, eLine);
    end
  endtask

  // Model of the stepping rules, written from R2..R7.
  task automatic modelStep(input bit up);
    if (up) begin
      if (mOnes < 16) mOnes++;
      else if (mCoarse < 7) begin mOnes = 0; mCoarse++; end
    end else begin
      if (mOnes > 0) mOnes--;
      else if (mCoarse > 0) begin mOnes = 16; mCoarse--; end
    end
  endtask

  task automatic doStep(input bit up);
    @(negedge clk);
    stepEn = 1'b1;
    stepUp = up;
    @(negedge clk);
    stepEn = 1'b0;
    modelStep(up);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 reset", 0, 0);

    foreach (VEC[v]) begin
      doStep(VEC[v][8]);
      checkState("R2/R3/R7 table", int'(VEC[v][7:3]), int'(VEC[v][2:0]));
    end

    // R8: stepUp toggles with no strobe
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      stepUp = k[0];
    end
    @(negedge clk);
    checkState("R8 idle", mOnes, mCoarse);

    // Fill the fine field, then R4 carry, then R5 borrow
    while (mOnes < 16) doStep(1'b1);
    checkState("R2 full fine", mOnes, mCoarse);
    doStep(1'b1);
    checkState("R4 carry", 0, 1);
    doStep(1'b0);
    checkState("R5 borrow", 16, 0);

    // Climb to the top, checking each state
    while (!(mCoarse == 7 && mOnes == 16)) begin
      doStep(1'b1);
      checkState("R4/R10 climb", mOnes, mCoarse);
    end
    for (int k = 0; k < 3; k++) begin
      doStep(1'b1);
      checkState("R6 top hold", 16, 7);
    end

    // R8 at the top
    stepUp = 1'b0;
    repeat (3) @(negedge clk);
    checkState("R8 idle top", 16, 7);

    // Descend to the bottom
    while (!(mCoarse == 0 && mOnes == 0)) begin
      doStep(1'b0);
      checkState("R5/R3 descend", mOnes, mCoarse);
    end
    doStep(1'b0);
    checkState("R7 bottom hold", 0, 0);

    // Mid-range reset returns to R1 state
    repeat (20) doStep(1'b1);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mOnes = 0; mCoarse = 0;
    checkState("R1 reset again", 0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end
endmodule